// File: doc/BRIEF.md
# Supply Low-Voltage Interrupt Controller

This block is the digital control and status logic that sits around an analog supply-voltage comparator. Software picks a trip level and enables the monitor through a control word. It then waits until the voltage reference reports stable before it trusts the comparator. The block synchronizes the comparator's "supply is below the trip level" output and latches it into a sticky interrupt flag. From that flag it raises a registered interrupt request.

Software can lower the trip level and clear the flag each time the flag fires, and so follow a battery that drains slowly. After each change of trip level, detection is held off until the synchronizer holds only samples taken at the new level. Detection also runs while the core is in a sleep or idle state. In that state, a set and enabled flag produces a registered wake request. A companion output tells the core how to resume. It says "vector to the handler" when the interrupt's priority is above the current CPU priority, and "resume after the sleep instruction" otherwise.

Top module: `lvd_irq_ctrl`

## Requirements
- R1: Control word (wr_sel = 0): bits 11:8 hold the trip-level code, which is driven on thr_code, and bit 12 holds the monitor enable. All other bits read 0, and after reset the whole word reads 0.
- R2: Control bit 13 is read-only and reads 1 exactly when the enable is 1 and ref_ready has been sampled high through a two-flop synchronizer. A write to bit 13 has no effect.
- R3: cmp_below passes through a two-flop synchronizer. If it is high at clock edge k, and detection is allowed at that point, the flag reads 1 after edge k+2.
- R4: A comparator result is ignored while the monitor is disabled or while the bit-13 status is low, and the flag does not set.
- R5: Once set, the flag stays set until a write to the interrupt word (wr_sel = 1) with bit 4 equal to 0. Writing bit 4 as 1, or clearing the enable or the interrupt enable, leaves it unchanged.
- R6: If a flag-clear write and a new detection land on the same clock edge, the flag stays set.
- R7: Any control-word write blanks detection for the next two clock edges. After the trip level is lowered and the flag cleared, the flag therefore sets again only once the comparator reports a crossing of the new level.
- R8: Interrupt word: bit 0 is the interrupt enable and bits 3:1 are the 3-bit priority, both read/write. Bit 4 reads the flag. All other bits read 0.
- R9: irq equals the flag AND the interrupt enable, registered once.
- R10: wake is registered and goes high when low_power, the flag and the interrupt enable are all high at the preceding edge. Flag setting works the same whether low_power is high or low.
- R11: wake_vec is registered. It is 1 when a wake is raised and the priority is strictly greater than cpu_prio (enter the handler). It is 0 when the priority is less than or equal to cpu_prio (resume after the sleep instruction), and 0 whenever wake is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control word, 1 interrupt word |
| wr_data | input | 16 | Write data |
| cmp_below | input | 1 | Comparator: supply below the selected level |
| ref_ready | input | 1 | Voltage reference settled |
| cpu_prio | input | 3 | Current CPU priority |
| low_power | input | 1 | Core is in sleep or idle |
| thr_code | output | 4 | Trip-level code to the comparator |
| ctrl_word | output | 16 | Control word readback |
| intr_word | output | 16 | Interrupt word readback |
| irq | output | 1 | Interrupt request |
| wake | output | 1 | Wake request from sleep or idle |
| wake_vec | output | 1 | 1 enter handler, 0 resume in place |

## Verification
The collision that matters is a software write that clears the flag on the same edge that the synchronized comparator reports a new crossing. The bench provokes it by holding cmp_below high with the monitor enabled and the reference ready, then issuing clear writes. A behavioural reference model, stepped on every clock, expects the flag to stay set. A second collision is a trip-level write against comparator samples taken before the write. The bench lowers the level while the stale high samples are still in the synchronizer, and the model expects no flag until the blanking window ends.

// File: rtl/lvd_pkg.sv
package lvd_pkg;
  localparam int unsigned DATA_W       = 16;
  localparam int unsigned THR_W        = 4;
  localparam int unsigned PRIO_W       = 3;
  localparam int unsigned SYNC_STAGES  = 2;
  // control word layout
  localparam int unsigned CTL_THR_LSB  = 8;
  localparam int unsigned CTL_EN_BIT   = 12;
  localparam int unsigned CTL_RDY_BIT  = 13;
  // interrupt word layout
  localparam int unsigned INT_IE_BIT   = 0;
  localparam int unsigned INT_PRI_LSB  = 1;
  localparam int unsigned INT_FLAG_BIT = 4;

  typedef enum logic {
    SEL_CTRL = 1'b0,
    SEL_INTR = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/lvd_sync.sv
module lvd_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;
  logic [STAGES-1:0][WIDTH-1:0] stg_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb stg_d = d;
    end else begin : g_chain
      always_comb stg_d = {stg_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/lvd_regs.sv
module lvd_regs
  import lvd_pkg::*;
#(
  parameter int unsigned DW     = DATA_W,
  parameter int unsigned TW     = THR_W,
  parameter int unsigned PW     = PRIO_W,
  parameter int unsigned STAGES = SYNC_STAGES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          cmp_s,
  input  logic          rdy_s,
  output logic [TW-1:0] thr_o,
  output logic          ie_o,
  output logic [PW-1:0] prio_o,
  output logic          flag_o,
  output logic [DW-1:0] ctrl_word_o,
  output logic [DW-1:0] intr_word_o
);
  localparam int unsigned BW         = $clog2(STAGES + 1);
  localparam logic [BW-1:0] BLANK_LD = BW'(STAGES);

  logic [TW-1:0] thr_q, thr_d;
  logic          en_q, en_d;
  logic          ie_q, ie_d;
  logic [PW-1:0] prio_q, prio_d;
  logic          flag_q, flag_d;
  logic [BW-1:0] blank_q, blank_d;

  logic ctrl_wr, intr_wr, clr, rdy, det;
  logic unused_wr_bits;

  assign unused_wr_bits = ^{wr_data[DW-1:CTL_RDY_BIT], wr_data[CTL_THR_LSB-1:INT_FLAG_BIT+1]};

  // next-state
  always_comb begin
    ctrl_wr = wr_en && (wr_sel == SEL_CTRL);
    intr_wr = wr_en && (wr_sel == SEL_INTR);
    clr     = intr_wr && !wr_data[INT_FLAG_BIT];
    rdy     = en_q && rdy_s;
    det     = rdy && cmp_s && (blank_q == '0);

    thr_d   = ctrl_wr ? wr_data[CTL_THR_LSB +: TW] : thr_q;
    en_d    = ctrl_wr ? wr_data[CTL_EN_BIT]        : en_q;
    ie_d    = intr_wr ? wr_data[INT_IE_BIT]        : ie_q;
    prio_d  = intr_wr ? wr_data[INT_PRI_LSB +: PW] : prio_q;

    if (ctrl_wr)              blank_d = BLANK_LD;
    else if (blank_q != '0)   blank_d = blank_q - BW'(1);
    else                      blank_d = blank_q;

    // detection takes precedence over a clear
    flag_d = det || (flag_q && !clr);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q   <= '0;
      en_q    <= 1'b0;
      ie_q    <= 1'b0;
      prio_q  <= '0;
      flag_q  <= 1'b0;
      blank_q <= '0;
    end else begin
      thr_q   <= thr_d;
      en_q    <= en_d;
      ie_q    <= ie_d;
      prio_q  <= prio_d;
      flag_q  <= flag_d;
      blank_q <= blank_d;
    end
  end

  always_comb begin
    ctrl_word_o = '0;
    ctrl_word_o[CTL_THR_LSB +: TW] = thr_q;
    ctrl_word_o[CTL_EN_BIT]        = en_q;
    ctrl_word_o[CTL_RDY_BIT]       = rdy;
    intr_word_o = '0;
    intr_word_o[INT_IE_BIT]        = ie_q;
    intr_word_o[INT_PRI_LSB +: PW] = prio_q;
    intr_word_o[INT_FLAG_BIT]      = flag_q;
  end

  assign thr_o  = thr_q;
  assign ie_o   = ie_q;
  assign prio_o = prio_q;
  assign flag_o = flag_q;

  // R5
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q);
  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (det && clr) |=> flag_q);
  // R4
  off_noset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_q && (!en_q || !rdy_s)) |=> !flag_q);
  // R7
  blank_noset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_q && blank_q != '0) |=> !flag_q);
endmodule

// File: rtl/lvd_wake.sv
module lvd_wake
  import lvd_pkg::*;
#(
  parameter int unsigned PW = PRIO_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flag_i,
  input  logic          ie_i,
  input  logic [PW-1:0] prio_i,
  input  logic [PW-1:0] cpu_prio_i,
  input  logic          low_power_i,
  output logic          irq_o,
  output logic          wake_o,
  output logic          wake_vec_o
);
  logic irq_q, irq_d, wake_q, wake_d, vec_q, vec_d;

  always_comb begin
    irq_d  = flag_i && ie_i;
    wake_d = low_power_i && irq_d;
    vec_d  = wake_d && (prio_i > cpu_prio_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q  <= 1'b0;
      wake_q <= 1'b0;
      vec_q  <= 1'b0;
    end else begin
      irq_q  <= irq_d;
      wake_q <= wake_d;
      vec_q  <= vec_d;
    end
  end

  assign irq_o      = irq_q;
  assign wake_o     = wake_q;
  assign wake_vec_o = vec_q;

  // R9
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_i && ie_i) |=> irq_o);
  // R9
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ie_i |=> !irq_o);
  // R10
  wake_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !low_power_i |=> !wake_o);
  // R11
  wake_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (low_power_i && flag_i && ie_i && prio_i > cpu_prio_i) |=> (wake_o && wake_vec_o));
  // R11
  wake_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (low_power_i && flag_i && ie_i && prio_i <= cpu_prio_i) |=> (wake_o && !wake_vec_o));
endmodule

// File: rtl/lvd_irq_ctrl.sv
module lvd_irq_ctrl
  import lvd_pkg::*;
#(
  parameter int unsigned DW     = DATA_W,
  parameter int unsigned TW     = THR_W,
  parameter int unsigned PW     = PRIO_W,
  parameter int unsigned STAGES = SYNC_STAGES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          cmp_below,
  input  logic          ref_ready,
  input  logic [PW-1:0] cpu_prio,
  input  logic          low_power,
  output logic [TW-1:0] thr_code,
  output logic [DW-1:0] ctrl_word,
  output logic [DW-1:0] intr_word,
  output logic          irq,
  output logic          wake,
  output logic          wake_vec
);
  logic [1:0]    sync_q;
  logic          ie, flag;
  logic [PW-1:0] prio;

  lvd_sync #(.WIDTH(2), .STAGES(STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({ref_ready, cmp_below}),
    .q     (sync_q)
  );

  lvd_regs #(.DW(DW), .TW(TW), .PW(PW), .STAGES(STAGES)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .wr_data     (wr_data),
    .cmp_s       (sync_q[0]),
    .rdy_s       (sync_q[1]),
    .thr_o       (thr_code),
    .ie_o        (ie),
    .prio_o      (prio),
    .flag_o      (flag),
    .ctrl_word_o (ctrl_word),
    .intr_word_o (intr_word)
  );

  lvd_wake #(.PW(PW)) u_wake (
    .clk         (clk),
    .rst_n       (rst_n),
    .flag_i      (flag),
    .ie_i        (ie),
    .prio_i      (prio),
    .cpu_prio_i  (cpu_prio),
    .low_power_i (low_power),
    .irq_o       (irq),
    .wake_o      (wake),
    .wake_vec_o  (wake_vec)
  );
endmodule

// File: tb/sim_lvd_irq_ctrl.sv
module sim_lvd_irq_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, wr_en, wr_sel, cmp_below, ref_ready, low_power;
  logic [15:0] wr_data;
  logic [2:0]  cpu_prio;
  logic [3:0]  thr_code;
  logic [15:0] ctrl_word, intr_word;
  logic        irq, wake, wake_vec;

  lvd_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cmp_below(cmp_below), .ref_ready(ref_ready), .cpu_prio(cpu_prio),
    .low_power(low_power), .thr_code(thr_code), .ctrl_word(ctrl_word),
    .intr_word(intr_word), .irq(irq), .wake(wake), .wake_vec(wake_vec)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // reference model state
  int m_thr = 0, m_prio = 0, m_blank = 0;
  bit m_en = 0, m_ie = 0, m_flag = 0, m_irq = 0, m_wake = 0, m_vec = 0, m_rdy = 0;
  bit cq[$], rq[$];

  task automatic chk(string tag, int got, int exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, got, exp);
    end
  endtask

  // one clock edge of the behavioural model; inputs are those held before the edge
  task automatic model_edge();
    bit c_seen, r_seen, det, clr;
    c_seen = (cq.size() >= 2) ? cq[cq.size()-2] : 1'b0;
    r_seen = (rq.size() >= 2) ? rq[rq.size()-2] : 1'b0;
    det = m_en && r_seen && c_seen && (m_blank == 0);
    clr = wr_en && wr_sel && !wr_data[4];
    m_irq  = m_flag && m_ie;
    m_wake = low_power && m_flag && m_ie;
    m_vec  = m_wake && (m_prio > int'(cpu_prio));
    m_flag = det || (m_flag && !clr);
    if (wr_en && !wr_sel) begin
      m_thr = int'(wr_data[11:8]);
      m_en  = wr_data[12];
      m_blank = 2;
    end else if (m_blank > 0) m_blank--;
    if (wr_en && wr_sel) begin
      m_ie   = wr_data[0];
      m_prio = int'(wr_data[3:1]);
    end
    cq.push_back(cmp_below);
    rq.push_back(ref_ready);
    if (cq.size() > 4) begin void'(cq.pop_front()); void'(rq.pop_front()); end
    m_rdy = rq[rq.size()-2 >= 0 ? rq.size()-2 : 0] && (rq.size() >= 2);
  endtask

  task automatic compare_all();
    int ectl, eint;
    ectl = (m_thr << 8) | (int'(m_en) << 12) | (int'(m_en && m_rdy) << 13);
    eint = int'(m_ie) | (m_prio << 1) | (int'(m_flag) << 4);
    chk("R1 thr_code", int'(thr_code), m_thr);
    chk("R1 R2 ctrl_word", int'(ctrl_word), ectl);
    chk("R8 intr_word ie/prio", int'(intr_word) & 16'hFFEF, eint & 16'hFFEF);
    chk("R3 R4 R5 R6 R7 flag", int'(intr_word[4]), int'(m_flag));
    chk("R9 irq", int'(irq), int'(m_irq));
    chk("R10 wake", int'(wake), int'(m_wake));
    chk("R11 wake_vec", int'(wake_vec), int'(m_vec));
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr(bit sel, logic [15:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    tick();
    wr_en = 1'b0; wr_data = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; wr_en = 0; wr_sel = 0; wr_data = '0; cmp_below = 0;
    ref_ready = 0; cpu_prio = '0; low_power = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    compare_all();                         // R1 reset state

    // R1 R2: program level 0xA, enable, write status bit (ignored), reference comes up
    wr(1'b0, 16'h3A00);
    run(2);
    ref_ready = 1;
    run(4);
    // R3: detection with interrupts masked
    cmp_below = 1;
    run(4);
    // R8 R9: enable interrupt at priority 4
    wr(1'b1, 16'h0019);
    run(2);
    // R5: writing flag bit as 1 keeps it; masking ie or disabling does not clear
    cmp_below = 0;
    run(3);
    wr(1'b1, 16'h0018);
    run(2);
    wr(1'b0, 16'h0A00);
    run(3);
    // R6: clear while detection continues
    wr(1'b0, 16'h1A00);
    wr(1'b1, 16'h0009);
    cmp_below = 1;
    run(4);
    wr(1'b1, 16'h0009);
    wr(1'b1, 16'h0009);
    run(2);
    // R7: lower level while stale highs sit in the synchronizer, then clear
    wr(1'b0, 16'h1500);
    cmp_below = 0;
    wr(1'b1, 16'h0009);
    run(5);
    cmp_below = 1;                          // new level crossed
    run(4);
    // R10 R11: sleep with cpu priority above, equal, below
    low_power = 1; cpu_prio = 3'd6; run(3);
    cpu_prio = 3'd4; run(3);
    cpu_prio = 3'd2; run(3);
    wr(1'b1, 16'h0018);                    // interrupt masked: no wake, no irq
    run(3);
    low_power = 0; run(2);
    // R4: disabled and reference low
    wr(1'b0, 16'h1500);
    wr(1'b1, 16'h0009);
    cmp_below = 0; run(3);
    wr(1'b0, 16'h0500);
    cmp_below = 1; run(5);
    wr(1'b0, 16'h1500);
    ref_ready = 0; run(6);
    ref_ready = 1; run(6);
    // random mix, all requirements
    for (int i = 0; i < 600; i++) begin
      cmp_below = ($urandom_range(0, 3) == 0);
      ref_ready = ($urandom_range(0, 9) != 0);
      low_power = $urandom_range(0, 1);
      cpu_prio  = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 5) == 0) wr(1'($urandom_range(0, 1)), 16'($urandom));
      else tick();
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule